// File: doc/BRIEF.md
# Inclusive L2 Coherence Line Controller

This block is the per-line protocol engine of a shared, inclusive second-level cache bank. It keeps a small MESI-style directory for a fixed group of private first-level caches. Upstream logic performs the tag lookup and classifies each incoming message into an event code. The controller holds one line's stable or transient state, a sharer bit vector, an exclusive owner ID, a pending-reader set, the ID of a pending exclusive requester, an invalidation-ack counter and a dirty flag.

For each event the controller decides three things. It picks the next state. It picks at most one outgoing command, whose destination vector can carry an extra invalidation fan-out. It either consumes the event (pop), stalls it for a later retry, or holds it while the command port is busy. When a blocked line settles into a stable state it raises a wake strobe so that stalled requests are retried.

A distinct feature is the owned-by-L1 state, in which the L2 copy is treated as stale. A read to that state is forwarded to the owner. The line then waits for the forwarded data and the requester's unblock, which may arrive in either order, before it becomes shared. The data array, the network, the memory and the tag match are outside the block. The `lineWe` strobe and the data-source select tell the surrounding datapath when to capture incoming data and when a message carries the line's data.

Top module: `lcc_line_ctrl`

## Requirements
- R1: After reset `lineState` is 0 (not present), `lineSharers` is 0, `lineDirty` is 0 and `cmdValid` is low.
- R2: In not-present (0), a read (event 0) moves to single-reader fetch (4), an instruction read (1) moves to multi-reader fetch (5), and an exclusive read (2) or upgrade (3) moves to exclusive fetch (6). Each issues command type 0 (fetch) with `cmdToMem`=1, `cmdDest`=0 and latency 2.
- R3: In state 4 or 5, a further read or instruction read adds the requester to the pending-reader set and moves to 5, with no command.
- R4: Memory data (event 6) in state 4 sends type 4 (exclusive data) to the single reader with latency 1 and moves to 7. In state 5 it sends type 3 (shared data) to all pending readers with latency 1, sets the sharers to those readers and moves to 1. In state 6 it sends type 4 to the exclusive requester and moves to 7. Each of these pulses `lineWe` and clears the dirty flag.
- R5: An exclusive unblock (event 11) in state 7 moves to the L1-owned state (3), sets the sharers to the sender alone, records the sender as owner and pulses `wakeUp`.
- R6: A read or instruction read in state 3 sends type 5 (forward read) to the owner with latency 1 and moves to 8. From 8, an unblock (10) moves to 9 and L1 data (8) moves to 10. The remaining message then moves the line to shared (1) with `wakeUp`. The unblock sender is added to the sharers, and L1 data pulses `lineWe` and ORs its dirty bit into the line.
- R7: A writeback (event 4) from the owner in state 3 sends type 8 (writeback ack) to it with latency 1, clears the sharers and moves to modified-in-L2 (2). `lineWe` pulses and the dirty flag is set only when `evDirty` is 1. A writeback from any other L1 gets only the ack, and the state is unchanged.
- R8: In shared (1), a read sends type 3 to the requester with latency 2 and adds it as a sharer. An exclusive read sends type 4 with latency 2 and an invalidation to the other sharers on `cmdInvDest`, then moves to 7. An upgrade from a current sharer sends type 9 (upgrade ack) with latency 1 and the same invalidation, then moves to 7.
- R9: A replacement (event 5) has three cases. In state 2 it sends type 1 (memory data) when dirty or type 2 (clean ack) when clean, to memory with latency 2, and moves to 13. In state 1 it sends type 7 (invalidate) to all sharers and moves to 12; the last of one ack (9) per sharer sends the memory message and moves to 13. In state 3 it sends type 7 to the owner and moves to 11; the owner's data sends the memory message and moves to 13.
- R10: A memory ack (7) in state 13 returns the line to 0 with sharers and dirty cleared, and pulses `wakeUp`.
- R11: Request events (0 to 5) arriving in transient states 6 to 13, and exclusive reads, upgrades, writebacks and replacements arriving in states 4 and 5, raise `evStall`. They cause no pop, no command and no state change.
- R12: While `cmdValid` is high and `cmdReady` is low, the event is not popped, and the state, sharers and dirty flag hold.
- R13: Events that have no meaning in the current state, such as a memory ack in state 0 or an L1 ack in state 3, are popped with no command and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evValid | input | 1 | Classified event present |
| evType | input | 4 | Event code |
| evSrc | input | IDW | Sending or requesting L1 |
| evDirty | input | 1 | Incoming data marked dirty |
| evPop | output | 1 | Event consumed this cycle |
| evStall | output | 1 | Event must be retried later |
| cmdValid | output | 1 | Outgoing command valid |
| cmdReady | input | 1 | Command accepted |
| cmdType | output | 4 | Message type code |
| cmdDest | output | N_L1 | L1 destination vector |
| cmdInvDest | output | N_L1 | Extra invalidation fan-out |
| cmdToMem | output | 1 | Command targets memory |
| cmdDataSel | output | 1 | Message carries the line's data |
| cmdLatency | output | LatW | Send delay in cycles |
| lineWe | output | 1 | Capture incoming data into the array |
| wakeUp | output | 1 | Retry stalled requests |
| lineState | output | 4 | Current state code |
| lineSharers | output | N_L1 | Sharer vector |
| lineOwner | output | IDW | Exclusive owner ID |
| lineDirty | output | 1 | Line dirty flag |

## Verification
Completion of a transaction and command-port backpressure can fall in the same cycle. This happens with the final invalidation ack of a shared-line eviction, which must both emit the memory writeback and advance the state. The bench presents that last ack with `cmdReady` low. It requires the command to be visible while no pop, no wake and no state or counter change occur. It then raises `cmdReady` and expects the transition exactly once. A stalled request in a blocked state is also presented alongside a pending wait, to confirm that stalls never disturb the pending handshake.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  typedef enum logic [3:0] {
    EV_RD = 4'd0, EV_IRD = 4'd1, EV_XRD = 4'd2, EV_UPG = 4'd3,
    EV_WB = 4'd4, EV_EVICT = 4'd5, EV_MEMDATA = 4'd6, EV_MEMACK = 4'd7,
    EV_L1DATA = 4'd8, EV_L1ACK = 4'd9, EV_UNBLK = 4'd10, EV_XUNBLK = 4'd11
  } ev_e;

  typedef enum logic [3:0] {
    ST_NP = 4'd0, ST_SHARED = 4'd1, ST_MOD = 4'd2, ST_OWNED = 4'd3,
    ST_FETCH_ONE = 4'd4, ST_FETCH_MANY = 4'd5, ST_FETCH_EX = 4'd6,
    ST_WAIT_XUNB = 4'd7, ST_RD_BOTH = 4'd8, ST_RD_DATA = 4'd9,
    ST_RD_UNB = 4'd10, ST_EV_OWNER = 4'd11, ST_EV_ACKS = 4'd12,
    ST_EV_MEM = 4'd13
  } st_e;

  typedef enum logic [3:0] {
    MSG_FETCH = 4'd0, MSG_MEM_DATA = 4'd1, MSG_MEM_CLEAN = 4'd2,
    MSG_DATA_SH = 4'd3, MSG_DATA_EX = 4'd4, MSG_FWD_RD = 4'd5,
    MSG_FWD_EX = 4'd6, MSG_INV = 4'd7, MSG_WB_ACK = 4'd8, MSG_UPG_ACK = 4'd9
  } msg_e;

  typedef enum logic [2:0] {
    DST_NONE, DST_SRC, DST_READERS, DST_XID, DST_OWNER, DST_SHARERS
  } dst_e;

  typedef enum logic [1:0] {LAT_REQ, LAT_RSP, LAT_L1} lat_e;

  typedef struct packed {
    logic readersSet;
    logic readersAdd;
    logic sharersFromReaders;
    logic sharersAdd;
    logic sharersOnlySrc;
    logic sharersClear;
    logic xidSet;
    logic dirtyClr;
    logic dirtyMerge;
    logic pendLoad;
    logic pendDec;
    logic clearAll;
  } strobe_t;

  function automatic logic isTransient(st_e s);
    return !(s inside {ST_NP, ST_SHARED, ST_MOD, ST_OWNED});
  endfunction
endpackage

// File: rtl/lcc_dir.sv
module lcc_dir
  import lcc_pkg::*;
#(
  parameter int N_L1 = 4,
  localparam int IDW = $clog2(N_L1),
  localparam int CW = $clog2(N_L1 + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  logic [IDW-1:0]  evSrc,
  input  logic            evDirty,
  input  dst_e            dstSel,
  input  logic            invOthers,
  output logic [N_L1-1:0] cmdDest,
  output logic [N_L1-1:0] cmdInvDest,
  output logic            srcIsSharer,
  output logic            srcIsOwner,
  output logic            pendingLast,
  output logic [N_L1-1:0] sharers,
  output logic [IDW-1:0]  owner,
  output logic            dirty
);
  localparam logic [N_L1-1:0] OneVec = 1;

  logic [N_L1-1:0] readers;
  logic [IDW-1:0]  xid;
  logic [CW-1:0]   pend;
  logic [N_L1-1:0] srcVec;

  assign srcVec = OneVec << evSrc;

  always_ff @(posedge clk) begin
    if (!rstN || strb.clearAll) begin
      sharers <= '0;
      readers <= '0;
      owner   <= '0;
      xid     <= '0;
      dirty   <= 1'b0;
      pend    <= '0;
    end else begin
      if (strb.readersSet) readers <= srcVec;
      else if (strb.readersAdd) readers <= readers | srcVec;

      if (strb.sharersFromReaders) sharers <= readers;
      else if (strb.sharersOnlySrc) sharers <= srcVec;
      else if (strb.sharersClear) sharers <= '0;
      else if (strb.sharersAdd) sharers <= sharers | srcVec;

      if (strb.sharersOnlySrc) owner <= evSrc;
      if (strb.xidSet) xid <= evSrc;

      if (strb.dirtyClr) dirty <= 1'b0;
      else if (strb.dirtyMerge) dirty <= dirty | evDirty;

      if (strb.pendLoad) pend <= CW'($countones(sharers));
      else if (strb.pendDec) pend <= pend - 1'b1;
    end
  end

  always_comb begin
    case (dstSel)
      DST_SRC:     cmdDest = srcVec;
      DST_READERS: cmdDest = readers;
      DST_XID:     cmdDest = OneVec << xid;
      DST_OWNER:   cmdDest = OneVec << owner;
      DST_SHARERS: cmdDest = sharers;
      default:     cmdDest = '0;
    endcase
  end

  assign cmdInvDest  = invOthers ? (sharers & ~srcVec) : '0;
  assign srcIsSharer = |(sharers & srcVec);
  assign srcIsOwner  = (owner == evSrc);
  assign pendingLast = (pend == CW'(1));
endmodule

// File: rtl/lcc_ctrl.sv
module lcc_ctrl
  import lcc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evValid,
  input  logic [3:0] evType,
  input  logic       evDirty,
  input  logic       cmdReady,
  input  logic       srcIsSharer,
  input  logic       srcIsOwner,
  input  logic       pendingLast,
  input  logic       lineDirtyNow,
  output st_e        state,
  output logic       evPop,
  output logic       evStall,
  output logic       cmdValid,
  output msg_e       msgSel,
  output dst_e       dstSel,
  output logic       invOthers,
  output logic       cmdToMem,
  output logic       cmdDataSel,
  output lat_e       latSel,
  output logic       lineWe,
  output logic       wakeUp,
  output strobe_t    strb
);
  ev_e     ev;
  st_e     nxt;
  logic    stall, send, we;
  strobe_t s;
  logic    isReq;

  assign ev    = ev_e'(evType);
  assign isReq = ev inside {EV_RD, EV_IRD, EV_XRD, EV_UPG, EV_WB, EV_EVICT};

  always_comb begin
    nxt = state; stall = 1'b0; send = 1'b0; msgSel = MSG_FETCH;
    dstSel = DST_NONE; invOthers = 1'b0; latSel = LAT_L1; we = 1'b0; s = '0;
    case (state)
      ST_NP: case (ev)
        EV_RD, EV_IRD: begin
          send = 1'b1; latSel = LAT_REQ; s.readersSet = 1'b1; s.dirtyClr = 1'b1;
          nxt = (ev == EV_RD) ? ST_FETCH_ONE : ST_FETCH_MANY;
        end
        EV_XRD, EV_UPG: begin
          send = 1'b1; latSel = LAT_REQ; s.xidSet = 1'b1; s.dirtyClr = 1'b1;
          nxt = ST_FETCH_EX;
        end
        EV_WB: begin send = 1'b1; msgSel = MSG_WB_ACK; dstSel = DST_SRC; end
        default: ;
      endcase
      ST_FETCH_ONE, ST_FETCH_MANY: case (ev)
        EV_RD, EV_IRD: begin s.readersAdd = 1'b1; nxt = ST_FETCH_MANY; end
        EV_MEMDATA: begin
          send = 1'b1; we = 1'b1; s.dirtyClr = 1'b1; dstSel = DST_READERS;
          if (state == ST_FETCH_ONE) begin
            msgSel = MSG_DATA_EX; nxt = ST_WAIT_XUNB;
          end else begin
            msgSel = MSG_DATA_SH; s.sharersFromReaders = 1'b1; nxt = ST_SHARED;
          end
        end
        default: stall = isReq;
      endcase
      ST_FETCH_EX: case (ev)
        EV_MEMDATA: begin
          send = 1'b1; we = 1'b1; s.dirtyClr = 1'b1; msgSel = MSG_DATA_EX;
          dstSel = DST_XID; nxt = ST_WAIT_XUNB;
        end
        default: stall = isReq;
      endcase
      ST_SHARED: case (ev)
        EV_RD, EV_IRD: begin
          send = 1'b1; msgSel = MSG_DATA_SH; dstSel = DST_SRC; latSel = LAT_RSP;
          s.sharersAdd = 1'b1;
        end
        EV_XRD, EV_UPG: begin
          send = 1'b1; dstSel = DST_SRC; invOthers = 1'b1; nxt = ST_WAIT_XUNB;
          if (ev == EV_UPG && srcIsSharer) msgSel = MSG_UPG_ACK;
          else begin msgSel = MSG_DATA_EX; latSel = LAT_RSP; end
        end
        EV_WB: begin send = 1'b1; msgSel = MSG_WB_ACK; dstSel = DST_SRC; end
        EV_EVICT: begin
          send = 1'b1; msgSel = MSG_INV; dstSel = DST_SHARERS; s.pendLoad = 1'b1;
          nxt = ST_EV_ACKS;
        end
        default: ;
      endcase
      ST_MOD: case (ev)
        EV_RD, EV_XRD, EV_UPG: begin
          send = 1'b1; msgSel = MSG_DATA_EX; dstSel = DST_SRC; latSel = LAT_RSP;
          nxt = ST_WAIT_XUNB;
        end
        EV_IRD: begin
          send = 1'b1; msgSel = MSG_DATA_SH; dstSel = DST_SRC; latSel = LAT_RSP;
          s.sharersAdd = 1'b1; nxt = ST_SHARED;
        end
        EV_WB: begin send = 1'b1; msgSel = MSG_WB_ACK; dstSel = DST_SRC; end
        EV_EVICT: begin
          send = 1'b1; latSel = LAT_RSP; nxt = ST_EV_MEM;
          msgSel = lineDirtyNow ? MSG_MEM_DATA : MSG_MEM_CLEAN;
        end
        default: ;
      endcase
      ST_OWNED: case (ev)
        EV_RD, EV_IRD: begin
          send = 1'b1; msgSel = MSG_FWD_RD; dstSel = DST_OWNER; nxt = ST_RD_BOTH;
        end
        EV_XRD, EV_UPG: begin
          send = 1'b1; msgSel = MSG_FWD_EX; dstSel = DST_OWNER; nxt = ST_WAIT_XUNB;
        end
        EV_WB: begin
          send = 1'b1; msgSel = MSG_WB_ACK; dstSel = DST_SRC;
          if (srcIsOwner) begin
            s.sharersClear = 1'b1; s.dirtyMerge = 1'b1; we = evDirty; nxt = ST_MOD;
          end
        end
        EV_EVICT: begin
          send = 1'b1; msgSel = MSG_INV; dstSel = DST_OWNER; nxt = ST_EV_OWNER;
        end
        default: ;
      endcase
      ST_WAIT_XUNB: case (ev)
        EV_XUNBLK: begin s.sharersOnlySrc = 1'b1; nxt = ST_OWNED; end
        default: stall = isReq;
      endcase
      ST_RD_BOTH: case (ev)
        EV_UNBLK:  begin s.sharersAdd = 1'b1; nxt = ST_RD_DATA; end
        EV_L1DATA: begin we = 1'b1; s.dirtyMerge = 1'b1; nxt = ST_RD_UNB; end
        default: stall = isReq;
      endcase
      ST_RD_DATA: case (ev)
        EV_L1DATA: begin we = 1'b1; s.dirtyMerge = 1'b1; nxt = ST_SHARED; end
        default: stall = isReq;
      endcase
      ST_RD_UNB: case (ev)
        EV_UNBLK: begin s.sharersAdd = 1'b1; nxt = ST_SHARED; end
        default: stall = isReq;
      endcase
      ST_EV_OWNER: case (ev)
        EV_L1DATA: begin
          send = 1'b1; we = 1'b1; s.dirtyMerge = 1'b1; latSel = LAT_RSP;
          msgSel = (lineDirtyNow | evDirty) ? MSG_MEM_DATA : MSG_MEM_CLEAN;
          nxt = ST_EV_MEM;
        end
        default: stall = isReq;
      endcase
      ST_EV_ACKS: case (ev)
        EV_L1ACK: begin
          s.pendDec = 1'b1;
          if (pendingLast) begin
            send = 1'b1; latSel = LAT_RSP; nxt = ST_EV_MEM;
            msgSel = lineDirtyNow ? MSG_MEM_DATA : MSG_MEM_CLEAN;
          end
        end
        default: stall = isReq;
      endcase
      ST_EV_MEM: case (ev)
        EV_MEMACK: begin s.clearAll = 1'b1; nxt = ST_NP; end
        default: stall = isReq;
      endcase
      default: nxt = ST_NP;
    endcase
  end

  assign evStall    = evValid & stall;
  assign cmdValid   = evValid & send & ~stall;
  assign evPop      = evValid & ~stall & (~send | cmdReady);
  assign lineWe     = evPop & we;
  assign strb       = evPop ? s : '0;
  assign wakeUp     = evPop & isTransient(state) & ~isTransient(nxt);
  assign cmdToMem   = msgSel inside {MSG_FETCH, MSG_MEM_DATA, MSG_MEM_CLEAN};
  assign cmdDataSel = msgSel inside {MSG_MEM_DATA, MSG_DATA_SH, MSG_DATA_EX};

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_NP;
    else if (evPop) state <= nxt;
  end
endmodule

// File: rtl/lcc_line_ctrl.sv
module lcc_line_ctrl
  import lcc_pkg::*;
#(
  parameter int N_L1 = 4,
  parameter int REQ_LAT = 2,
  parameter int RSP_LAT = 2,
  parameter int L1_LAT = 1,
  localparam int IDW = $clog2(N_L1),
  localparam int LatW = $clog2(REQ_LAT + RSP_LAT + L1_LAT + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            evValid,
  input  logic [3:0]      evType,
  input  logic [IDW-1:0]  evSrc,
  input  logic            evDirty,
  output logic            evPop,
  output logic            evStall,
  output logic            cmdValid,
  input  logic            cmdReady,
  output logic [3:0]      cmdType,
  output logic [N_L1-1:0] cmdDest,
  output logic [N_L1-1:0] cmdInvDest,
  output logic            cmdToMem,
  output logic            cmdDataSel,
  output logic [LatW-1:0] cmdLatency,
  output logic            lineWe,
  output logic            wakeUp,
  output logic [3:0]      lineState,
  output logic [N_L1-1:0] lineSharers,
  output logic [IDW-1:0]  lineOwner,
  output logic            lineDirty
);
  st_e     state;
  msg_e    msgSel;
  dst_e    dstSel;
  lat_e    latSel;
  strobe_t strb;
  logic    invOthers, srcIsSharer, srcIsOwner, pendingLast;

  lcc_ctrl uCtrl (
    .clk, .rstN, .evValid, .evType, .evDirty, .cmdReady,
    .srcIsSharer, .srcIsOwner, .pendingLast, .lineDirtyNow(lineDirty),
    .state, .evPop, .evStall, .cmdValid, .msgSel, .dstSel, .invOthers,
    .cmdToMem, .cmdDataSel, .latSel, .lineWe, .wakeUp, .strb
  );

  lcc_dir #(.N_L1(N_L1)) uDir (
    .clk, .rstN, .strb, .evSrc, .evDirty, .dstSel, .invOthers,
    .cmdDest, .cmdInvDest, .srcIsSharer, .srcIsOwner, .pendingLast,
    .sharers(lineSharers), .owner(lineOwner), .dirty(lineDirty)
  );

  always_comb begin
    case (latSel)
      LAT_REQ: cmdLatency = LatW'(REQ_LAT);
      LAT_RSP: cmdLatency = LatW'(RSP_LAT);
      default: cmdLatency = LatW'(L1_LAT);
    endcase
  end

  assign cmdType   = msgSel;
  assign lineState = state;
endmodule

// File: rtl/lcc_line_ctrl_chk.sv
module lcc_line_ctrl_chk
  import lcc_pkg::*;
#(
  parameter int N_L1 = 4,
  parameter int REQ_LAT = 2,
  localparam int IDW = $clog2(N_L1),
  localparam int LatW = $clog2(REQ_LAT + 4)
) (
  input logic            clk,
  input logic            rstN,
  input logic            evValid,
  input logic [3:0]      evType,
  input logic [IDW-1:0]  evSrc,
  input logic            evPop,
  input logic            evStall,
  input logic            cmdValid,
  input logic            cmdReady,
  input logic [3:0]      cmdType,
  input logic [N_L1-1:0] cmdDest,
  input logic            cmdToMem,
  input logic            wakeUp,
  input logic [3:0]      lineState,
  input logic [N_L1-1:0] lineSharers,
  input logic [IDW-1:0]  lineOwner,
  input logic            lineDirty
);
  localparam logic [N_L1-1:0] OneVec = 1;

  p_hold_under_backpressure_r12: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> $stable(lineState) && $stable(lineSharers) && $stable(lineDirty));

  p_stall_keeps_line_r11: assert property (@(posedge clk) disable iff (!rstN)
    evStall |=> $stable(lineState) && $stable(lineSharers));

  p_owner_is_sole_sharer_r5: assert property (@(posedge clk) disable iff (!rstN)
    lineState == 4'(ST_OWNED) |-> lineSharers == (OneVec << lineOwner));

  p_xunblock_sets_owner_r5: assert property (@(posedge clk) disable iff (!rstN)
    evValid && evPop && evType == 4'(EV_XUNBLK) && lineState == 4'(ST_WAIT_XUNB)
    |=> lineState == 4'(ST_OWNED) && lineOwner == $past(evSrc));

  p_absent_is_empty_r10: assert property (@(posedge clk) disable iff (!rstN)
    lineState == 4'(ST_NP) |-> lineSharers == '0 && !lineDirty);

  p_fetch_to_memory_r2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdType == 4'(MSG_FETCH) |-> cmdToMem && cmdDest == '0);

  p_wake_lands_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    wakeUp |=> lineState inside {4'(ST_NP), 4'(ST_SHARED), 4'(ST_OWNED)});
endmodule

bind lcc_line_ctrl lcc_line_ctrl_chk #(.N_L1(N_L1), .REQ_LAT(REQ_LAT)) uChk (.*);

// File: tb/tb_lcc_line_ctrl.sv
`timescale 1ns/1ps
module tb_lcc_line_ctrl;
  localparam int N = 4;
  localparam int IDW = 2;
  localparam int LatW = 3;

  logic clk = 0, rstN = 0;
  logic evValid = 0, evDirty = 0, cmdReady = 1;
  logic [3:0] evType = 0;
  logic [IDW-1:0] evSrc = 0;
  logic evPop, evStall, cmdValid, cmdToMem, cmdDataSel, lineWe, wakeUp, lineDirty;
  logic [3:0] cmdType, lineState;
  logic [N-1:0] cmdDest, cmdInvDest, lineSharers;
  logic [LatW-1:0] cmdLatency;
  logic [IDW-1:0] lineOwner;

  int nChecks = 0, nErr = 0;
  bit done = 0;

  // captured combinational outputs of the last applied event
  logic cV, cP, cS, cW, cWe, cM, cD;
  logic [3:0] cT;
  logic [N-1:0] cDst, cInv;
  int cL;

  always #4 clk = ~clk;

  lcc_line_ctrl dut (.*);

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input int t, input int s, input logic d, input logic rdy);
    @(negedge clk);
    evValid = 1; evType = 4'(t); evSrc = IDW'(s); evDirty = d; cmdReady = rdy;
    #1;
    cV = cmdValid; cP = evPop; cS = evStall; cW = wakeUp; cWe = lineWe;
    cM = cmdToMem; cD = cmdDataSel; cT = cmdType; cDst = cmdDest;
    cInv = cmdInvDest; cL = int'(cmdLatency);
    @(posedge clk); #1;
    evValid = 0; cmdReady = 1;
  endtask

  task automatic t_reset;
    #1;
    check("R1 state", lineState, 0);
    check("R1 sharers", lineSharers, 0);
    check("R1 dirty", lineDirty, 0);
    check("R1 cmdValid", cmdValid, 0);
  endtask

  task automatic t_single_reader;
    apply(0, 1, 0, 1);
    check("R2 fetch type", cT, 0); check("R2 toMem", cM, 1);
    check("R2 latency", cL, 2); check("R2 dest", cDst, 0);
    check("R2 state", lineState, 4);
    apply(6, 0, 0, 1);
    check("R4 excl data", cT, 4); check("R4 dest", cDst, 4'b0010);
    check("R4 lat", cL, 1); check("R4 we", cWe, 1); check("R4 state", lineState, 7);
    apply(2, 2, 0, 1);
    check("R11 stall", cS, 1); check("R11 nopop", cP, 0); check("R11 nocmd", cV, 0);
    check("R11 state", lineState, 7);
    apply(11, 1, 0, 1);
    check("R5 wake", cW, 1); check("R5 state", lineState, 3);
    check("R5 sharers", lineSharers, 4'b0010); check("R5 owner", lineOwner, 1);
  endtask

  task automatic t_owner_wb;
    apply(4, 2, 0, 1);
    check("R7 foreign ack", cT, 8); check("R7 foreign dest", cDst, 4'b0100);
    check("R7 foreign state", lineState, 3);
    apply(4, 1, 1, 1);
    check("R7 owner ack dest", cDst, 4'b0010); check("R7 we", cWe, 1);
    check("R7 state", lineState, 2); check("R7 sharers", lineSharers, 0);
    check("R7 dirty", lineDirty, 1);
  endtask

  task automatic t_evict_dirty;
    apply(5, 0, 0, 1);
    check("R9 mem data", cT, 1); check("R9 toMem", cM, 1); check("R9 lat", cL, 2);
    check("R9 datasel", cD, 1); check("R9 state", lineState, 13);
    apply(0, 0, 0, 1);
    check("R11 stall in evict", cS, 1); check("R11 evict state", lineState, 13);
    apply(7, 0, 0, 1);
    check("R10 wake", cW, 1); check("R10 state", lineState, 0);
    check("R10 dirty", lineDirty, 0);
  endtask

  task automatic t_multi_reader;
    apply(1, 0, 0, 1);
    check("R2 instr fetch state", lineState, 5);
    apply(0, 2, 0, 1);
    check("R3 merge nocmd", cV, 0); check("R3 pop", cP, 1); check("R3 state", lineState, 5);
    apply(2, 3, 0, 1);
    check("R11 xread stalled", cS, 1);
    apply(6, 0, 0, 1);
    check("R4 shared data", cT, 3); check("R4 readers dest", cDst, 4'b0101);
    check("R4 wake", cW, 1); check("R4 state", lineState, 1);
    check("R4 sharers", lineSharers, 4'b0101);
    apply(0, 3, 0, 1);
    check("R8 shared reply", cT, 3); check("R8 dest", cDst, 4'b1000);
    check("R8 lat", cL, 2); check("R8 sharers", lineSharers, 4'b1101);
    apply(3, 2, 0, 1);
    check("R8 upg ack", cT, 9); check("R8 upg dest", cDst, 4'b0100);
    check("R8 inv others", cInv, 4'b1001); check("R8 upg lat", cL, 1);
    check("R8 upg state", lineState, 7);
    apply(11, 2, 0, 1);
    check("R5 new owner", lineOwner, 2); check("R5 sharers2", lineSharers, 4'b0100);
  endtask

  task automatic t_fwd_read;
    apply(0, 0, 0, 1);
    check("R6 fwd", cT, 5); check("R6 fwd dest", cDst, 4'b0100);
    check("R6 lat", cL, 1); check("R6 state", lineState, 8);
    apply(8, 2, 0, 1);
    check("R6 data first", lineState, 10); check("R6 we", cWe, 1);
    apply(10, 0, 0, 1);
    check("R6 wake", cW, 1); check("R6 shared", lineState, 1);
    check("R6 sharers", lineSharers, 4'b0101);
    apply(2, 1, 0, 1);
    check("R8 excl data", cT, 4); check("R8 inv", cInv, 4'b0101);
    check("R8 excl lat", cL, 2); check("R8 state", lineState, 7);
    apply(11, 1, 0, 1);
    apply(1, 3, 0, 1);
    check("R6 fwd2 dest", cDst, 4'b0010);
    apply(10, 3, 0, 1);
    check("R6 unblock first", lineState, 9);
    apply(8, 1, 1, 1);
    check("R6 wake2", cW, 1); check("R6 shared2", lineState, 1);
    check("R6 sharers2", lineSharers, 4'b1010); check("R6 dirty", lineDirty, 1);
  endtask

  task automatic t_backpressure;
    apply(5, 0, 0, 0);
    check("R12 inv visible", cV, 1); check("R9 inv type", cT, 7);
    check("R9 inv dest", cDst, 4'b1010);
    check("R12 nopop", cP, 0); check("R12 state held", lineState, 1);
    apply(5, 0, 0, 1);
    check("R9 acks state", lineState, 12);
    apply(9, 1, 0, 1);
    check("R9 first ack nocmd", cV, 0); check("R9 first ack state", lineState, 12);
    apply(9, 3, 0, 0);
    check("R12 last ack cmd", cV, 1); check("R9 last ack type", cT, 1);
    check("R12 last ack nopop", cP, 0); check("R12 no wake", cW, 0);
    check("R12 last ack held", lineState, 12);
    apply(9, 3, 0, 1);
    check("R9 last ack done", lineState, 13);
    apply(7, 0, 0, 1);
    check("R10 back to np", lineState, 0);
  endtask

  task automatic t_excl_and_ignored;
    apply(7, 0, 0, 1);
    check("R13 ignored pop", cP, 1); check("R13 nocmd", cV, 0);
    check("R13 state", lineState, 0);
    apply(2, 3, 0, 1);
    check("R2 excl fetch state", lineState, 6); check("R2 excl fetch type", cT, 0);
    apply(6, 0, 0, 1);
    check("R4 excl fetch data dest", cDst, 4'b1000); check("R4 excl state", lineState, 7);
    apply(11, 3, 0, 1);
    check("R5 owner3", lineOwner, 3);
    apply(9, 0, 0, 1);
    check("R13 ack in owned nocmd", cV, 0); check("R13 owned state", lineState, 3);
    apply(5, 0, 0, 1);
    check("R9 owner inv", cT, 7); check("R9 owner inv dest", cDst, 4'b1000);
    check("R9 owner state", lineState, 11);
    apply(8, 3, 0, 1);
    check("R9 clean ack", cT, 2); check("R9 clean datasel", cD, 0);
    check("R9 clean lat", cL, 2); check("R9 clean state", lineState, 13);
    apply(7, 0, 0, 1);
    check("R10 final", lineState, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    t_reset();
    t_single_reader();
    t_owner_wb();
    t_evict_dirty();
    t_multi_reader();
    t_fwd_read();
    t_backpressure();
    t_excl_and_ignored();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nChecks++; nErr++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end
endmodule